// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets synchronous logic use an external asynchronous static RAM with 19 address bits and 8 data bits. A host hands it one access at a time through a request port with valid/ready flow control. Each access becomes a read or write sequence on the memory pins. Read data returns on a response strobe.

Every analog timing window of the memory is a parameter counted in whole clock cycles. Each count is the ceiling of the nanosecond figure divided by the clock period. The parameters cover read cycle, address access, output-enable access, output-enable release, write pulse, address-to-write-end, data setup and write cycle. The controller sequences the chip enable, write enable and output enable strobes from these counts. It drives the data pins through a split tri-state bus: a value, a driver enable and the value seen on the pins. It never turns its drivers on while the memory may still be driving.

Back-pressure applies to requests only. A request moves when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is high only while the controller is idle, so the host must hold a request steady until it is taken. The response is a one-cycle strobe and cannot be stalled; the host must take it when it comes.

Top module: `asram_bridge`

## Requirements
- R1: During reset and whenever `req_ready` is high, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are high and `mem_dq_oe` is low.
- R2: A request is taken at a clock edge where `req_valid` and `req_ready` are both high. From that edge until the access completes, `req_ready` stays low. Request pins that change during that time start no extra access and change nothing in memory.
- R3: A read (`req_wr` = 0) holds `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high for max(TRC, TAA, TDOE) cycles. `rsp_valid` pulses high for exactly one cycle. `rsp_rdata` holds the pin value sampled at the edge that ends cycle max(TAA, TDOE).
- R4: A write (`req_wr` = 1) keeps `mem_oe_n` high throughout. `mem_ce_n` and `mem_we_n` stay low together for exactly max(max(TPWE, TAW), D + max(TSD, 1)) cycles, where D is the number of write cycles that pass before the data drivers turn on.
- R5: During a write, `mem_dq_out` carries the accepted `req_wdata`. `mem_dq_oe` is high and the value stable for at least max(TSD, 1) cycles before `mem_we_n` rises. The drivers stay on until the access completes.
- R6: A write keeps `req_ready` low for max(TWC, W + 1) cycles, where W is the write-enable low time of R4.
- R7: `mem_dq_oe` is never high while `mem_oe_n` is low. After `mem_oe_n` rises, the drivers turn on no earlier than THZOE cycles later. For a write taken one cycle after a read ends, D = max(THZOE - 1, 0).
- R8: `mem_addr` takes `req_addr` at acceptance and does not change until the next acceptance.
- R9: A read returns the byte most recently written to that address. This holds when the read directly follows the write, and when a write directly follows a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Memory address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle strobe: read data available |
| rsp_rdata | output | 8 | Read byte |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 19 | Memory address lines |
| mem_dq_out | output | 8 | Value for the data pins |
| mem_dq_oe | output | 1 | Data pin driver enable |
| mem_dq_in | input | 8 | Value seen on the data pins |

## Verification
The controller runs against a cycle model of the memory. The model returns the inverted byte whenever a read is sampled before the access windows have elapsed. It stores a corrupted byte whenever a write pulse, address window or data setup falls short. It also flags any cycle in which both sides may drive the pins. So a data mismatch separates a timing fault from a sequencing fault, and contention is reported separately.

Isolated writes and reads check the exact cycle counts. Read-then-write pairs check the turnaround delay, and write-then-read pairs check that stored data comes back. The all-zeros and all-ones bytes at the lowest and highest addresses check the address and data paths at their extremes. A read during which the request pins keep changing checks that busy-time requests are ignored. A fixed-seed random mix of reads and writes checks data integrity over many addresses.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WACT  = 2'd2,
    ST_WTAIL = 2'd3
  } asram_st_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_turn.sv
// Tracks how long the memory output drivers may still be active after
// output enable rises, and gates the controller's own data drivers.
module asram_turn #(
  parameter int unsigned HZ = 4,
  parameter int unsigned HW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_q,       // current (registered) output enable, active low
  input  logic oe_d,       // next value of output enable
  output logic drv_allow,  // drivers may turn on at the coming edge
  output logic hz_quiet    // release window fully elapsed
);
  localparam logic [HW-1:0] K_HZ = HW'(HZ);

  logic [HW-1:0] hz_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hz_q <= '0;
    else if (!oe_q && oe_d)  hz_q <= K_HZ;
    else if (hz_q != '0)     hz_q <= hz_q - 1'b1;
  end

  assign drv_allow = (hz_q <= HW'(1));
  assign hz_quiet  = (hz_q == '0);

  // R7: the release window restarts at the edge where output enable rises
  assert_hz_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> (hz_q == K_HZ));

endmodule

// File: rtl/asram_seq.sv
// Access sequencer: strobe generation and cycle counting.
module asram_seq import asram_pkg::*; #(
  parameter int unsigned CW     = 6,
  parameter int unsigned RD_CAP = 9,
  parameter int unsigned RD_END = 9,
  parameter int unsigned WE_MIN = 8,
  parameter int unsigned TSD    = 4,
  parameter int unsigned TWC    = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_wr,
  input  logic drv_allow,
  output logic req_ready,
  output logic accept,
  output logic capture,
  output logic ce_n,
  output logic we_n,
  output logic oe_n,
  output logic oe_n_next,
  output logic drv_on
);
  localparam int unsigned TSD_EFF = (TSD == 0) ? 1 : TSD;
  localparam logic [CW-1:0] K_RDCAP = CW'(RD_CAP);
  localparam logic [CW-1:0] K_RDEND = CW'(RD_END);
  localparam logic [CW-1:0] K_WEMIN = CW'(WE_MIN);
  localparam logic [CW-1:0] K_TSD   = CW'(TSD_EFF);
  localparam logic [CW-1:0] K_TWC   = CW'(TWC);

  asram_st_e   st_q, st_d;
  logic [CW-1:0] el_q, el_d, dc_q, dc_d;
  logic [CW-1:0] el_inc, dc_inc;
  logic ce_q, we_q, oe_q, drv_q;
  logic ce_d, we_d, oe_d, drv_d;
  logic cap_d;

  assign el_inc = el_q + 1'b1;
  assign dc_inc = dc_q + CW'(drv_q);

  always_comb begin
    st_d  = st_q;
    el_d  = el_inc;
    dc_d  = dc_q;
    ce_d  = ce_q;
    we_d  = we_q;
    oe_d  = oe_q;
    drv_d = drv_q;
    cap_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        el_d = '0;
        dc_d = '0;
        if (req_valid) begin
          ce_d = 1'b0;
          if (req_wr) begin
            st_d  = ST_WACT;
            we_d  = 1'b0;
            drv_d = drv_allow;
          end else begin
            st_d = ST_READ;
            oe_d = 1'b0;
          end
        end
      end
      ST_READ: begin
        cap_d = (el_inc == K_RDCAP);
        if (el_inc >= K_RDEND) begin
          st_d = ST_IDLE;
          ce_d = 1'b1;
          oe_d = 1'b1;
        end
      end
      ST_WACT: begin
        dc_d  = dc_inc;
        drv_d = drv_q | drv_allow;
        if ((el_inc >= K_WEMIN) && drv_q && (dc_inc >= K_TSD)) begin
          st_d = ST_WTAIL;
          we_d = 1'b1;
          ce_d = 1'b1;
        end
      end
      ST_WTAIL: begin
        if (el_inc >= K_TWC) begin
          st_d  = ST_IDLE;
          drv_d = 1'b0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      el_q  <= '0;
      dc_q  <= '0;
      ce_q  <= 1'b1;
      we_q  <= 1'b1;
      oe_q  <= 1'b1;
      drv_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      el_q  <= el_d;
      dc_q  <= dc_d;
      ce_q  <= ce_d;
      we_q  <= we_d;
      oe_q  <= oe_d;
      drv_q <= drv_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign capture   = cap_d;
  assign ce_n      = ce_q;
  assign we_n      = we_q;
  assign oe_n      = oe_q;
  assign oe_n_next = oe_d;
  assign drv_on    = drv_q;

  // R4: write enable and output enable are never low together
  assert_we_oe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_q |-> oe_q);

  // R4/R5: the pulse lasted the minimum and data was being driven at its end
  assert_we_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_q) |-> ((el_q >= K_WEMIN) && drv_q));

  // R6: a write cycle never returns to idle before its minimum length
  assert_wr_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && ($past(st_q) == ST_WTAIL)) |-> ($past(el_q) + 1'b1 >= K_TWC));

endmodule

// File: rtl/asram_dpath.sv
// Address, write data and read capture registers.
module asram_dpath #(
  parameter int unsigned AW = 19,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] pin_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] dout_q,
  output logic [DW-1:0] rdata_q,
  output logic          rsp_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      dout_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      dout_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= capture;
      if (capture) rdata_q <= pin_in;
    end
  end

  // R3: the response strobe lasts a single cycle
  assert_rsp_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_q |=> !rsp_q);

endmodule

// File: rtl/asram_bridge.sv
module asram_bridge import asram_pkg::*; #(
  parameter int unsigned AW    = 19,
  parameter int unsigned DW    = 8,
  parameter int unsigned TRC   = 9,
  parameter int unsigned TAA   = 9,
  parameter int unsigned TDOE  = 5,
  parameter int unsigned THZOE = 4,
  parameter int unsigned TPWE  = 7,
  parameter int unsigned TAW   = 8,
  parameter int unsigned TSD   = 4,
  parameter int unsigned TWC   = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  // TAA, TDOE and TPWE must be at least 1.
  localparam int unsigned RD_CAP  = umax(TAA, TDOE);
  localparam int unsigned RD_END  = umax(TRC, RD_CAP);
  localparam int unsigned WE_MIN  = umax(TPWE, TAW);
  localparam int unsigned CNT_LIM = RD_END + TWC + WE_MIN + TSD + THZOE + 2;
  localparam int unsigned CW      = $clog2(CNT_LIM + 1);
  localparam int unsigned HW      = $clog2(THZOE + 2);

  logic accept, capture, oe_n_next, drv_allow, hz_quiet;

  asram_seq #(
    .CW(CW), .RD_CAP(RD_CAP), .RD_END(RD_END),
    .WE_MIN(WE_MIN), .TSD(TSD), .TWC(TWC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_wr(req_wr), .drv_allow(drv_allow),
    .req_ready(req_ready), .accept(accept), .capture(capture),
    .ce_n(mem_ce_n), .we_n(mem_we_n), .oe_n(mem_oe_n),
    .oe_n_next(oe_n_next), .drv_on(mem_dq_oe)
  );

  asram_turn #(.HZ(THZOE), .HW(HW)) u_turn (
    .clk(clk), .rst_n(rst_n),
    .oe_q(mem_oe_n), .oe_d(oe_n_next),
    .drv_allow(drv_allow), .hz_quiet(hz_quiet)
  );

  asram_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk(clk), .rst_n(rst_n),
    .accept(accept), .capture(capture),
    .req_addr(req_addr), .req_wdata(req_wdata), .pin_in(mem_dq_in),
    .addr_q(mem_addr), .dout_q(mem_dq_out),
    .rdata_q(rsp_rdata), .rsp_q(rsp_valid)
  );

  // R1: idle means every strobe released and the data drivers off
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  // R7: drivers never on while the memory output enable is asserted
  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R7: drivers on only after the release window has fully elapsed
  assert_drv_after_hz_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> hz_quiet);

  // R8: address held while the chip stays selected
  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

// File: tb/asram_bridge_tb.sv
module asram_bridge_tb;
  localparam int PER     = 8;
  localparam int TRC_C   = (70 + PER - 1) / PER;
  localparam int TAA_C   = (70 + PER - 1) / PER;
  localparam int TDOE_C  = (35 + PER - 1) / PER;
  localparam int THZ_C   = (25 + PER - 1) / PER;
  localparam int TPWE_C  = (55 + PER - 1) / PER;
  localparam int TAW_C   = (60 + PER - 1) / PER;
  localparam int TSD_C   = (30 + PER - 1) / PER;
  localparam int TWC_C   = (70 + PER - 1) / PER;
  localparam int RD_NEED = (TAA_C > TDOE_C) ? TAA_C : TDOE_C;
  localparam int RD_BUSY = (TRC_C > RD_NEED) ? TRC_C : RD_NEED;
  localparam logic [18:0] AMAX = 19'h7FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_wr = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] rsp_rdata, mem_dq_out;
  logic [7:0] mem_dq_in = '0;
  logic [18:0] mem_addr;

  int checks = 0, fails = 0;
  int contention = 0, viol = 0, we_oe_low = 0;
  bit prev_read = 0;

  always #(PER/2) clk = ~clk;

  asram_bridge #(
    .TRC(TRC_C), .TAA(TAA_C), .TDOE(TDOE_C), .THZOE(THZ_C),
    .TPWE(TPWE_C), .TAW(TAW_C), .TSD(TSD_C), .TWC(TWC_C)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // ---------------- memory model (evaluated once per cycle) ----------------
  logic [7:0] shadow [int unsigned];
  logic [7:0] expv   [int unsigned];
  logic [18:0] m_last_addr = '0;
  logic [7:0]  m_last_dout = '0;
  logic        m_last_drv = 0, m_last_wlow = 0, m_last_oe = 1;
  int m_wl = 0, m_aw = 0, m_ds = 0, m_rd = 0, m_hz = 0;

  function automatic logic [7:0] mem_val(input logic [18:0] a);
    return shadow.exists(a) ? shadow[a] : 8'h00;
  endfunction

  always @(negedge clk) begin
    logic wlow, rcond, mdrv;
    wlow  = !mem_ce_n && !mem_we_n;
    rcond = !mem_ce_n && !mem_oe_n && mem_we_n;
    if (rst_n) begin
      // write completes on the first cycle after both strobes were low
      if (m_last_wlow && !wlow) begin
        if (m_wl >= TPWE_C && m_aw >= TAW_C && m_ds >= TSD_C)
          shadow[m_last_addr] = m_last_dout;
        else begin
          shadow[m_last_addr] = ~m_last_dout;
          viol++;
        end
      end
      if (!mem_we_n && !mem_oe_n) we_oe_low++;
      // memory output release window after output enable rises
      if (!mem_oe_n) m_hz = 0;
      else if (!m_last_oe) m_hz = 1;
      else if (m_hz != 0 && m_hz <= THZ_C) m_hz++;
      mdrv = rcond || (m_hz != 0 && m_hz <= THZ_C);
      if (mdrv && mem_dq_oe) contention++;
    end
    m_aw = (mem_addr == m_last_addr) ? m_aw + 1 : 1;
    m_wl = wlow ? m_wl + 1 : 0;
    m_ds = mem_dq_oe ? ((m_last_drv && mem_dq_out == m_last_dout) ? m_ds + 1 : 1) : 0;
    m_rd = rcond ? ((mem_addr == m_last_addr) ? m_rd + 1 : 1) : 0;
    mem_dq_in = (m_rd >= RD_NEED) ? mem_val(mem_addr) : ~mem_val(mem_addr);
    m_last_addr = mem_addr;
    m_last_dout = mem_dq_out;
    m_last_drv  = mem_dq_oe;
    m_last_wlow = wlow;
    m_last_oe   = mem_oe_n;
  end

  // ---------------- bench helpers ----------------
  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int wr_busy(input bit after_read);
    int d, wl;
    d  = after_read ? max2(THZ_C - 1, 0) : 0;
    wl = max2(max2(TPWE_C, TAW_C), d + max2(TSD_C, 1));
    return max2(TWC_C, wl + 1);
  endfunction

  function automatic logic [7:0] pat(input logic [18:0] a, input int i);
    return a[7:0] ^ a[15:8] ^ {a[18:16], 5'd0} ^ 8'(i * 37);
  endfunction

  task automatic access(input bit wr, input logic [18:0] a, input logic [7:0] d,
                        input bit noisy, input logic [18:0] na,
                        output int busy, output int nrsp, output logic [7:0] rd);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_wr = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    if (noisy) begin
      req_wr = 1; req_addr = na; req_wdata = ~d;
    end else req_valid = 0;
    busy = 0; nrsp = 0; rd = '0;
    forever begin
      if (rsp_valid) begin nrsp++; rd = rsp_rdata; end
      if (req_ready) break;
      busy++;
      @(negedge clk);
    end
    req_valid = 0;
  endtask

  task automatic do_write(input logic [18:0] a, input logic [7:0] d);
    int busy, nrsp;
    logic [7:0] rd;
    bit ar;
    ar = prev_read;
    access(1, a, d, 0, '0, busy, nrsp, rd);
    chk(ar ? "R7 write-after-read busy" : "R6 write busy", busy, wr_busy(ar));
    expv[a] = d;
    prev_read = 0;
  endtask

  task automatic do_read(input logic [18:0] a, input bit noisy, input logic [18:0] na);
    int busy, nrsp;
    logic [7:0] rd;
    access(0, a, 8'h00, noisy, na, busy, nrsp, rd);
    chk(noisy ? "R2 busy with noisy pins" : "R3 read busy", busy, RD_BUSY);
    chk("R3 single strobe", nrsp, 1);
    chk("R9 read data", int'(rd), expv.exists(a) ? int'(expv[a]) : 0);
    prev_read = 1;
  endtask

  // ---------------- stimulus ----------------
  logic [18:0] pool [64];
  int npool = 0;

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    // R1: reset levels
    chk("R1 ce_n", int'(mem_ce_n), 1);
    chk("R1 we_n", int'(mem_we_n), 1);
    chk("R1 oe_n", int'(mem_oe_n), 1);
    chk("R1 dq_oe", int'(mem_dq_oe), 0);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready after reset", int'(req_ready), 1);

    // directed extremes, R8 address/data paths
    do_write(19'h00000, 8'hFF);
    do_write(AMAX, 8'h00);
    do_read(19'h00000, 0, '0);
    do_read(AMAX, 0, '0);
    // write right after read (R7), read right after write (R9)
    do_write(19'h12345, 8'hA5);
    do_read(19'h12345, 0, '0);
    do_write(19'h2AAAA, 8'h5A);
    do_read(19'h2AAAA, 0, '0);
    // R2: pins churn while busy; the churn target must keep its value
    do_read(19'h00000, 1, AMAX);
    do_read(AMAX, 0, '0);

    // constrained random mix
    for (int i = 0; i < 60; i++) begin
      bit wr;
      logic [18:0] a;
      wr = (npool < 4) || (($urandom % 100) < 45);
      if (wr) begin
        a = 19'($urandom);
        if (npool < 64) begin pool[npool] = a; npool++; end
        do_write(a, pat(a, i));
      end else begin
        a = pool[$urandom % npool];
        do_read(a, 0, '0);
      end
    end

    repeat (THZ_C + 2) @(negedge clk);
    chk("R7 contention cycles", contention, 0);
    chk("R5 write timing violations", viol, 0);
    chk("R4 we and oe low together", we_oe_low, 0);
    chk("R1 idle after run", int'(req_ready && mem_ce_n && !mem_dq_oe), 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule